// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block generates the digital drive pattern for a time-multiplexed segment LCD with up to eight common (COM) and forty-four segment (SEG) electrodes. Each output pin carries a small level index, not a voltage. An external resistor or capacitor bias ladder turns that index into one of the bias voltages. The block steps through the COM rows one time slot at a time. In each slot it puts one row at an extreme level and drives every segment to an on or off level taken from the pixel bits of that row. At the end of every frame it mirrors all levels, so that each pixel sees no net DC over a pair of frames.

The pixel image is held in two buffers. Software writes rows into a write buffer at any time. An update request copies the whole write buffer into the display buffer at the next frame boundary, and a one-cycle done pulse marks the frame in which the new image first appears. Up to eight individually chosen pixels can blink. A frame-based divider sets the blink rate, and the chosen pixels are blanked during the off half of each blink period. The block runs from a slow clock, with the slot length set by a divider input.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset, phase is 0, frame_start and upd_done are 0, both buffers are all zero, COM 0 is the selected row and every segment shows the off level.
- R2: Each COM slot lasts slot_div+1 clock cycles. A frame holds N slots, where duty_sel codes 0,1,2,3,4 give N = 1,2,3,4,8 and codes 5 to 7 act as 8. frame_start is high for the first cycle of every frame.
- R3: With top level T = bias_sel+1 (codes 0..3 mean static, 1/2, 1/3, 1/4 bias), the selected COM is at T in phase 0 and at 0 in phase 1. The other used COMs are at 1 in phase 0 and at T-1 in phase 1. Levels are 3-bit fields, and COM j occupies com_lvl[3j+2:3j].
- R4: A COM whose index is N or more is held at the unselected level of the current phase in every slot.
- R5: A lit segment is at 0 in phase 0 and at T in phase 1. A dark segment is at O in phase 0 and at T-O in phase 1, where O = 1 for static bias and 2 otherwise. SEG s occupies seg_lvl[3s+2:3s].
- R6: phase toggles at every frame start and holds its value within a frame.
- R7: wr_en stores wr_data into write-buffer row wr_row, with bit s feeding SEG s. This has no effect on the outputs until an update is taken.
- R8: upd_req arms a pending update. At the next frame boundary the write buffer is copied to the display buffer, and upd_done is high for one cycle together with frame_start. Frames without a copy leave upd_done low.
- R9: While blink_en is 1 and the blink state is in its off half, each enabled blink entry k (blink_px_com field k, blink_px_seg field k) forces its pixel dark. Entries that are not enabled, and all other pixels, are unaffected. With blink_en at 0 no pixel is blanked.
- R10: The blink state toggles every blink_div+1 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed drive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duty_sel | input | 3 | Duty code (rows per frame) |
| bias_sel | input | 2 | Bias code (number of levels) |
| slot_div | input | SLOT_W | Slot length minus one, in cycles |
| wr_en | input | 1 | Write one row of the write buffer |
| wr_row | input | COM_W | Row written |
| wr_data | input | NUM_SEG | Pixel bits of the row |
| upd_req | input | 1 | Request a buffer copy at the next frame boundary |
| blink_en | input | 1 | Global blink enable |
| blink_div | input | BDIV_W | Blink half-period minus one, in frames |
| blink_px_en | input | BLINK_N | Per-entry blink enable |
| blink_px_com | input | BLINK_N*COM_W | Row of each blink entry |
| blink_px_seg | input | BLINK_N*SEG_W | Segment of each blink entry |
| com_lvl | output | NUM_COM*3 | Level index per COM pin |
| seg_lvl | output | NUM_SEG*3 | Level index per SEG pin |
| phase | output | 1 | Current drive polarity |
| frame_start | output | 1 | First cycle of a frame |
| upd_done | output | 1 | Display buffer was refreshed this frame |

## Verification
The scan is exercised with row patterns that differ in every row, so a wrong row index or a swapped segment order shows up as a mismatch. Each duty and bias pairing (static/static, 1/2/1/2, 1/4/1/3, 1/8/1/4) is checked over two frames, which separates errors in the level table from errors in the phase mirroring. The idle-row rule is checked under the short duties. Buffer behaviour is tested by writing without a request and then with one, which separates leaky writes from a missing or early copy. Blink is sampled over consecutive frames with two divider settings, with an enabled entry, a disabled entry and a plain lit neighbour. This tells the blink rate apart from the pixel selection.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        DRV_COM_SEL,
        DRV_COM_UNSEL,
        DRV_SEG_ON,
        DRV_SEG_OFF
    } drive_e;

    // highest level index for a bias code: static=1, 1/2=2, 1/3=3, 1/4=4
    function automatic lvl_t bias_top(input logic [1:0] bias);
        return lvl_t'(bias) + lvl_t'(1);
    endfunction

    // rows per frame for a duty code; unknown codes act as 1/8
    function automatic logic [3:0] duty_rows(input logic [2:0] duty);
        case (duty)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd3;
            3'd3:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // level for one drive role; phase 1 mirrors around the ladder
    function automatic lvl_t drive_level(input drive_e kind, input logic [1:0] bias,
                                         input logic ph);
        lvl_t top;
        lvl_t base;
        top = bias_top(bias);
        case (kind)
            DRV_COM_SEL:   base = top;
            DRV_COM_UNSEL: base = lvl_t'(1);
            DRV_SEG_ON:    base = lvl_t'(0);
            default:       base = (top == lvl_t'(1)) ? lvl_t'(1) : lvl_t'(2);
        endcase
        return ph ? (top - base) : base;
    endfunction

endpackage

// File: rtl/lcd_seq.sv
module lcd_seq #(
    parameter int NUM_COM = 8,
    parameter int SLOT_W  = 8,
    parameter int BDIV_W  = 4,
    localparam int COM_W  = $clog2(NUM_COM),
    localparam int ROW_W  = COM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        duty_sel,
    input  logic [SLOT_W-1:0] slot_div,
    input  logic [BDIV_W-1:0] blink_div,
    output logic [COM_W-1:0]  com_idx,
    output logic [ROW_W-1:0]  active_rows,
    output logic              phase,
    output logic              frame_start,
    output logic              frame_wrap,
    output logic              blink_off
);
    import lcd_pkg::*;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [COM_W-1:0]  idx;
        logic              phase;
        logic              fstart;
        logic [BDIV_W-1:0] bcnt;
        logic              boff;
    } seq_t;

    seq_t s_d, s_q;
    int   rows_i;
    logic wrap_d;

    always_comb begin
        rows_i = int'(duty_rows(duty_sel));
        if (rows_i > NUM_COM) begin
            rows_i = NUM_COM;
        end
    end

    always_comb begin
        s_d        = s_q;
        s_d.fstart = 1'b0;
        wrap_d     = 1'b0;
        if (s_q.slot >= slot_div) begin
            s_d.slot = '0;
            if (int'(s_q.idx) >= rows_i - 1) begin
                wrap_d     = 1'b1;
                s_d.idx    = '0;
                s_d.phase  = ~s_q.phase;
                s_d.fstart = 1'b1;
                if (s_q.bcnt >= blink_div) begin
                    s_d.bcnt = '0;
                    s_d.boff = ~s_q.boff;
                end else begin
                    s_d.bcnt = s_q.bcnt + 1'b1;
                end
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else begin
            s_d.slot = s_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign com_idx     = s_q.idx;
    assign active_rows = ROW_W'(rows_i);
    assign phase       = s_q.phase;
    assign frame_start = s_q.fstart;
    assign frame_wrap  = wrap_d;
    assign blink_off   = s_q.boff;

endmodule

// File: rtl/lcd_frame_buf.sv
module lcd_frame_buf #(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 44,
    localparam int COM_W  = $clog2(NUM_COM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [COM_W-1:0]   wr_row,
    input  logic [NUM_SEG-1:0] wr_data,
    input  logic               upd_req,
    input  logic               frame_wrap,
    input  logic [COM_W-1:0]   rd_row,
    output logic [NUM_SEG-1:0] rd_data,
    output logic               upd_done
);

    typedef struct packed {
        logic [NUM_COM-1:0][NUM_SEG-1:0] wbuf;
        logic [NUM_COM-1:0][NUM_SEG-1:0] dbuf;
        logic                            pend;
        logic                            done;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d      = b_q;
        b_d.done = 1'b0;
        // copy uses the registered write buffer, so it is a clean frame image
        if (frame_wrap && b_q.pend) begin
            b_d.dbuf = b_q.wbuf;
            b_d.pend = 1'b0;
            b_d.done = 1'b1;
        end
        if (upd_req) begin
            b_d.pend = 1'b1;
        end
        if (wr_en && (int'(wr_row) < NUM_COM)) begin
            b_d.wbuf[wr_row] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_data  = b_q.dbuf[rd_row];
    assign upd_done = b_q.done;

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map #(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 44,
    parameter int BLINK_N = 8,
    localparam int COM_W  = $clog2(NUM_COM),
    localparam int SEG_W  = $clog2(NUM_SEG),
    localparam int ROW_W  = COM_W + 1,
    localparam int LW     = lcd_pkg::LVL_W
) (
    input  logic [1:0]               bias_sel,
    input  logic                     phase,
    input  logic [COM_W-1:0]         com_idx,
    input  logic [ROW_W-1:0]         active_rows,
    input  logic [NUM_SEG-1:0]       row_data,
    input  logic                     blink_active,
    input  logic [BLINK_N-1:0]       blink_px_en,
    input  logic [BLINK_N*COM_W-1:0] blink_px_com,
    input  logic [BLINK_N*SEG_W-1:0] blink_px_seg,
    output logic [NUM_COM*LW-1:0]    com_lvl,
    output logic [NUM_SEG*LW-1:0]    seg_lvl
);
    import lcd_pkg::*;

    lvl_t sel_l, unsel_l, on_l, off_l;

    always_comb begin
        sel_l   = drive_level(DRV_COM_SEL,   bias_sel, phase);
        unsel_l = drive_level(DRV_COM_UNSEL, bias_sel, phase);
        on_l    = drive_level(DRV_SEG_ON,    bias_sel, phase);
        off_l   = drive_level(DRV_SEG_OFF,   bias_sel, phase);
    end

    for (genvar j = 0; j < NUM_COM; j++) begin : g_com
        always_comb begin
            if (j >= int'(active_rows)) begin
                com_lvl[j*LW +: LW] = unsel_l;
            end else if (j == int'(com_idx)) begin
                com_lvl[j*LW +: LW] = sel_l;
            end else begin
                com_lvl[j*LW +: LW] = unsel_l;
            end
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic hide;
        logic lit;
        always_comb begin
            hide = 1'b0;
            for (int k = 0; k < BLINK_N; k++) begin
                if (blink_px_en[k]
                    && (blink_px_com[k*COM_W +: COM_W] == com_idx)
                    && (int'(blink_px_seg[k*SEG_W +: SEG_W]) == s)) begin
                    hide = 1'b1;
                end
            end
            lit = row_data[s] & ~(hide & blink_active);
            seg_lvl[s*LW +: LW] = lit ? on_l : off_l;
        end
    end

endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive #(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 44,
    parameter int BLINK_N = 8,
    parameter int SLOT_W  = 8,
    parameter int BDIV_W  = 4,
    localparam int COM_W  = $clog2(NUM_COM),
    localparam int SEG_W  = $clog2(NUM_SEG),
    localparam int ROW_W  = COM_W + 1,
    localparam int LW     = lcd_pkg::LVL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               duty_sel,
    input  logic [1:0]               bias_sel,
    input  logic [SLOT_W-1:0]        slot_div,
    input  logic                     wr_en,
    input  logic [COM_W-1:0]         wr_row,
    input  logic [NUM_SEG-1:0]       wr_data,
    input  logic                     upd_req,
    input  logic                     blink_en,
    input  logic [BDIV_W-1:0]        blink_div,
    input  logic [BLINK_N-1:0]       blink_px_en,
    input  logic [BLINK_N*COM_W-1:0] blink_px_com,
    input  logic [BLINK_N*SEG_W-1:0] blink_px_seg,
    output logic [NUM_COM*LW-1:0]    com_lvl,
    output logic [NUM_SEG*LW-1:0]    seg_lvl,
    output logic                     phase,
    output logic                     frame_start,
    output logic                     upd_done
);

    logic [COM_W-1:0]   com_idx;
    logic [ROW_W-1:0]   active_rows;
    logic               frame_wrap;
    logic               blink_off;
    logic [NUM_SEG-1:0] row_data;

    lcd_seq #(
        .NUM_COM(NUM_COM), .SLOT_W(SLOT_W), .BDIV_W(BDIV_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .slot_div(slot_div),
        .blink_div(blink_div), .com_idx(com_idx), .active_rows(active_rows),
        .phase(phase), .frame_start(frame_start), .frame_wrap(frame_wrap),
        .blink_off(blink_off)
    );

    lcd_frame_buf #(
        .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_data(wr_data), .upd_req(upd_req), .frame_wrap(frame_wrap),
        .rd_row(com_idx), .rd_data(row_data), .upd_done(upd_done)
    );

    lcd_level_map #(
        .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .BLINK_N(BLINK_N)
    ) u_map (
        .bias_sel(bias_sel), .phase(phase), .com_idx(com_idx),
        .active_rows(active_rows), .row_data(row_data),
        .blink_active(blink_en & blink_off), .blink_px_en(blink_px_en),
        .blink_px_com(blink_px_com), .blink_px_seg(blink_px_seg),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk #(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 44,
    localparam int LW     = lcd_pkg::LVL_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            bias_sel,
    input logic [NUM_COM*LW-1:0] com_lvl,
    input logic [NUM_SEG*LW-1:0] seg_lvl,
    input logic                  phase,
    input logic                  frame_start,
    input logic                  upd_done
);

    logic [LW-1:0] top, extreme, dark;
    logic          range_ok;
    logic          seg_ok;
    int            n_extreme;

    always_comb begin
        top      = LW'(bias_sel) + LW'(1);
        extreme  = phase ? LW'(0) : top;
        dark     = (top == LW'(1)) ? LW'(1) : LW'(2);
        dark     = phase ? (top - dark) : dark;
        range_ok = 1'b1;
        seg_ok   = 1'b1;
        n_extreme = 0;
        for (int j = 0; j < NUM_COM; j++) begin
            if (com_lvl[j*LW +: LW] > top) range_ok = 1'b0;
            if (com_lvl[j*LW +: LW] == extreme) n_extreme++;
        end
        for (int s = 0; s < NUM_SEG; s++) begin
            if (seg_lvl[s*LW +: LW] > top) range_ok = 1'b0;
            if ((seg_lvl[s*LW +: LW] != (phase ? top : LW'(0)))
                && (seg_lvl[s*LW +: LW] != dark)) seg_ok = 1'b0;
        end
    end

    assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        range_ok);

    assert_single_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_sel != 2'd0) |-> (n_extreme <= 1));

    assert_seg_two_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seg_ok);

    assert_phase_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (phase != $past(phase)));

    assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> $stable(phase));

    assert_done_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> frame_start);

endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_chk (
    .clk(clk), .rst_n(rst_n), .bias_sel(bias_sel), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .phase(phase), .frame_start(frame_start),
    .upd_done(upd_done)
);

// File: tb/tb_lcd_mux_drive.sv
module tb_lcd_mux_drive;
    localparam int NC = 8;
    localparam int NS = 44;
    localparam int BN = 8;
    localparam int CW = 3;
    localparam int SW = 6;
    localparam int SD = 2;      // slot_div used throughout

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] duty_sel = 3'd4;
    logic [1:0] bias_sel = 2'd2;
    logic [7:0] slot_div = 8'(SD);
    logic wr_en = 1'b0;
    logic [CW-1:0] wr_row = '0;
    logic [NS-1:0] wr_data = '0;
    logic upd_req = 1'b0;
    logic blink_en = 1'b0;
    logic [3:0] blink_div = '0;
    logic [BN-1:0] blink_px_en = '0;
    logic [BN*CW-1:0] blink_px_com = '0;
    logic [BN*SW-1:0] blink_px_seg = '0;
    logic [NC*3-1:0] com_lvl;
    logic [NS*3-1:0] seg_lvl;
    logic phase, frame_start, upd_done;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lcd_mux_drive dut (
        .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .bias_sel(bias_sel),
        .slot_div(slot_div), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .upd_req(upd_req), .blink_en(blink_en), .blink_div(blink_div),
        .blink_px_en(blink_px_en), .blink_px_com(blink_px_com),
        .blink_px_seg(blink_px_seg), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
        .phase(phase), .frame_start(frame_start), .upd_done(upd_done)
    );

    function automatic logic [NS-1:0] pat(input int r);
        return {4{11'(r * 149 + 83)}};
    endfunction

    function automatic int e_top(input int b); return b + 1; endfunction
    function automatic int e_sel(input int b, input logic p);
        return p ? 0 : e_top(b);
    endfunction
    function automatic int e_unsel(input int b, input logic p);
        return p ? e_top(b) - 1 : 1;
    endfunction
    function automatic int e_on(input int b, input logic p);
        return p ? e_top(b) : 0;
    endfunction
    function automatic int e_off(input int b, input logic p);
        int o;
        o = (e_top(b) == 1) ? 1 : 2;
        return p ? e_top(b) - o : o;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_frame();
        int guard = 0;
        @(negedge clk);
        while (!frame_start && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic next_slot();
        repeat (SD + 1) @(negedge clk);
    endtask

    task automatic write_row(input int r, input logic [NS-1:0] d);
        wr_en = 1'b1; wr_row = CW'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // compare all pins of the current slot against the requirement tables
    task automatic check_slot(input int k, input int rows, input logic [NS-1:0] d,
                              input string req);
        int b = int'(bias_sel);
        logic p = phase;
        int bad_c = 0, bad_s = 0, act = 0, exp = 0;
        for (int j = 0; j < NC; j++) begin
            int e = (j < rows && j == k) ? e_sel(b, p) : e_unsel(b, p);
            if (int'(com_lvl[j*3 +: 3]) != e) begin
                bad_c++; act = int'(com_lvl[j*3 +: 3]); exp = e;
            end
        end
        chk(bad_c == 0, {req, " com"}, act, exp);
        for (int s = 0; s < NS; s++) begin
            int e = d[s] ? e_on(b, p) : e_off(b, p);
            if (int'(seg_lvl[s*3 +: 3]) != e) begin
                bad_s++; act = int'(seg_lvl[s*3 +: 3]); exp = e;
            end
        end
        chk(bad_s == 0, {req, " seg"}, act, exp);
    endtask

    task automatic scan_frame(input int rows, input string req);
        for (int k = 0; k < rows; k++) begin
            check_slot(k, rows, pat(k), req);
            if (k < rows - 1) next_slot();
        end
    endtask

    task automatic t_reset();
        chk(phase == 1'b0, "R1 phase", int'(phase), 0);
        chk(frame_start == 1'b0 && upd_done == 1'b0, "R1 flags",
            int'({frame_start, upd_done}), 0);
        check_slot(0, 8, '0, "R1");
    endtask

    task automatic t_frame_len();
        int n;
        duty_sel = 3'd2;
        wait_frame();
        n = 0;
        do begin @(negedge clk); n++; end while (!frame_start && n < 200);
        chk(n == 3 * (SD + 1), "R2 frame length 1/3", n, 3 * (SD + 1));
        duty_sel = 3'd4;
        wait_frame();
        n = 0;
        do begin @(negedge clk); n++; end while (!frame_start && n < 200);
        chk(n == 8 * (SD + 1), "R2 frame length 1/8", n, 8 * (SD + 1));
    endtask

    task automatic t_update();
        for (int r = 0; r < NC; r++) write_row(r, pat(r));
        wait_frame();
        check_slot(0, 8, '0, "R7 no update yet");
        upd_req = 1'b1; @(negedge clk); upd_req = 1'b0;
        wait_frame();
        chk(upd_done == 1'b1, "R8 done with frame", int'(upd_done), 1);
        check_slot(0, 8, pat(0), "R8 copied");
        wait_frame();
        chk(upd_done == 1'b0, "R8 done single", int'(upd_done), 0);
    endtask

    task automatic t_scan(input int duty, input int bias, input int rows, input string req);
        logic p0;
        duty_sel = 3'(duty); bias_sel = 2'(bias);
        wait_frame();
        wait_frame();
        p0 = phase;
        scan_frame(rows, req);
        wait_frame();
        chk(phase == ~p0, "R6 phase toggles", int'(phase), int'(~p0));
        scan_frame(rows, req);
    endtask

    task automatic t_no_leak();
        write_row(0, ~pat(0));
        wait_frame(); wait_frame();
        check_slot(0, 4, pat(0), "R7 write hidden");
        upd_req = 1'b1; @(negedge clk); upd_req = 1'b0;
        wait_frame();
        check_slot(0, 4, ~pat(0), "R7 write shown");
    endtask

    // sample row 1 over n frames; bit i of result = seg5 dark in frame i
    task automatic blink_run(input int n, output logic [7:0] dark, input string req);
        dark = '0;
        for (int f = 0; f < n; f++) begin
            wait_frame();
            next_slot();
            dark[f] = (int'(seg_lvl[5*3 +: 3]) == e_off(int'(bias_sel), phase));
            chk(int'(seg_lvl[6*3 +: 3]) == e_on(int'(bias_sel), phase), {req, " neighbour"},
                int'(seg_lvl[6*3 +: 3]), e_on(int'(bias_sel), phase));
            chk(int'(seg_lvl[7*3 +: 3]) == e_on(int'(bias_sel), phase), {req, " disabled entry"},
                int'(seg_lvl[7*3 +: 3]), e_on(int'(bias_sel), phase));
        end
    endtask

    task automatic t_blink();
        logic [7:0] dk;
        int ch;
        write_row(1, '1);
        upd_req = 1'b1; @(negedge clk); upd_req = 1'b0;
        wait_frame();
        blink_px_com = '0; blink_px_seg = '0;
        blink_px_com[0 +: CW] = CW'(1); blink_px_seg[0 +: SW] = SW'(5);
        blink_px_com[CW +: CW] = CW'(1); blink_px_seg[SW +: SW] = SW'(7);
        blink_px_en = 8'b0000_0001;
        blink_en = 1'b1; blink_div = 4'd0;
        wait_frame();
        blink_run(4, dk, "R9");
        chk(dk[3:0] == 4'b0101 || dk[3:0] == 4'b1010, "R10 div0 alternates",
            int'(dk[3:0]), 5);
        blink_div = 4'd1;
        wait_frame(); wait_frame(); wait_frame();
        blink_run(4, dk, "R9");
        ch = {dk[0] ^ dk[1], dk[1] ^ dk[2], dk[2] ^ dk[3]};
        chk(ch == 3'b101 || ch == 3'b010, "R10 div1 period", ch, 5);
        blink_en = 1'b0;
        blink_run(3, dk, "R9 off");
        chk(dk[2:0] == 3'b000, "R9 blink disabled", int'(dk[2:0]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();                              // R1
        t_frame_len();                          // R2
        t_update();                             // R7 R8
        t_scan(3, 2, 4, "R3 R4 R5 1/4 1/3");
        t_scan(0, 0, 1, "R4 R5 static");
        t_scan(1, 1, 2, "R3 R4 1/2 1/2");
        t_scan(4, 3, 8, "R3 R5 1/8 1/4");
        duty_sel = 3'd3; bias_sel = 2'd2;
        t_no_leak();                            // R7
        t_blink();                              // R9 R10
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule